// File: doc/BRIEF.md
# Sequential Integer Divider with Divide-by-Zero Flag Reporting

This block divides a 32-bit dividend by a 32-bit divisor, in either two's-complement or unsigned arithmetic, and produces the quotient after a fixed number of clock cycles. It uses a restoring shift-and-subtract loop that runs on operand magnitudes. It also keeps two sticky status flags, an overflow flag and a carry flag. A division updates only the flag that belongs to its mode.

A one-cycle start pulse carries the operands, the mode select and the overflow-exception enable. A zero divisor is caught in the cycle the start is accepted, and the iteration loop does not run. Signed mode reports the fault on the overflow flag and unsigned mode reports it on the carry flag. The quotient register keeps its old value, and a quotient-valid output goes low so that the consumer skips writeback. A range-exception pulse goes out with the done strobe only when the exception enable was high at start.

Top module: `int_divider`

## Requirements
- R1: A signed division with a nonzero divisor returns the quotient truncated toward zero, with quotValid high, clears ovFlag and leaves cyFlag unchanged.
- R2: A signed division with a zero divisor sets ovFlag, leaves cyFlag unchanged, leaves the quotient output at its previous value and drives quotValid low.
- R3: An unsigned division with a nonzero divisor returns the unsigned quotient, with quotValid high, clears cyFlag and leaves ovFlag unchanged.
- R4: An unsigned division with a zero divisor sets cyFlag, leaves ovFlag unchanged, leaves the quotient output at its previous value and drives quotValid low.
- R5: rangeExc is high for exactly the done cycle of a zero-divisor division whose ovExcEn was 1 at start, and is low at every other time.
- R6: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 and clears ovFlag.
- R7: done is high for one cycle. It rises 34 rising clock edges after the accepting edge (counting that edge) for a nonzero divisor, and after the accepting edge itself for a zero divisor. A start presented during that done cycle is accepted.
- R8: A start pulse while a division is in progress is ignored. The running division finishes on time with its own result, and the flags and rangeExc are not affected by the ignored pulse.
- R9: After reset, quotient, quotValid, ovFlag, cyFlag, done and rangeExc are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start pulse; operands are sampled with it |
| signedMode | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor |
| ovExcEn | input | 1 | Enables the range exception on a zero divisor |
| quotient | output | 32 | Last quotient written |
| quotValid | output | 1 | 1 when the last completion wrote a quotient |
| ovFlag | output | 1 | Sticky overflow flag (signed zero divisor) |
| cyFlag | output | 1 | Sticky carry flag (unsigned zero divisor) |
| done | output | 1 | One-cycle completion strobe |
| rangeExc | output | 1 | One-cycle range-exception pulse |

## Verification
Two events can share one cycle. The first is the done strobe that ends a long division. The second is the acceptance of a new start, whose divisor may be zero and so complete on the very next edge. The bench makes this happen by raising a zero-divisor start in the same cycle that it sees done from a normal division. It then expects a second done on the next cycle that carries the right flag and rangeExc, with the quotient from the first division left unchanged. A start raised during the iteration loop is also checked: it must leave the latency, the result and both flags untouched.

// File: rtl/divz_pkg.sv
package divz_pkg;

  // strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;    // capture operand magnitudes
    logic step;    // one shift-subtract iteration
    logic finish;  // apply sign and publish quotient
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

endpackage

// File: rtl/divz_datapath.sv
module divz_datapath
  import divz_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divisorZero,
  output logic [WIDTH-1:0] quotient
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] remR;
  logic [WIDTH-1:0] quoR;
  logic [WIDTH-1:0] dvsR;
  logic             negR;
  logic [WIDTH-1:0] quotR;

  logic [WIDTH-1:0] magA;
  logic [WIDTH-1:0] magB;
  logic             negNext;
  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   trial;
  logic             fits;

  assign divisorZero = (divisor == '0);

  // operand magnitudes and result sign
  always_comb begin
    magA    = dividend;
    magB    = divisor;
    negNext = 1'b0;
    if (signedMode) begin
      if (dividend[MSB]) magA = '0 - dividend;
      if (divisor[MSB])  magB = '0 - divisor;
      negNext = dividend[MSB] ^ divisor[MSB];
    end
  end

  // one restoring iteration
  always_comb begin
    shifted = {remR, quoR[MSB]};
    trial   = shifted - {1'b0, dvsR};
    fits    = ~trial[WIDTH];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      dvsR  <= '0;
      negR  <= 1'b0;
      quotR <= '0;
    end else begin
      if (ctrl.load) begin
        remR <= '0;
        quoR <= magA;
        dvsR <= magB;
        negR <= negNext;
      end else if (ctrl.step) begin
        remR <= fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
        quoR <= {quoR[MSB-1:0], fits};
      end
      if (ctrl.finish) begin
        quotR <= negR ? ('0 - quoR) : quoR;
      end
    end
  end

  assign quotient = quotR;

endmodule

// File: rtl/divz_control.sv
module divz_control
  import divz_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    signedMode,
  input  logic    ovExcEn,
  input  logic    divisorZero,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done,
  output logic    rangeExc,
  output logic    quotValid,
  output logic    ovFlag,
  output logic    cyFlag
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  divState_t     state;
  logic [CW-1:0] iterCnt;
  logic          modeR;
  logic          accept;

  assign accept      = (state == ST_IDLE) && startIn;
  assign busy        = (state != ST_IDLE);
  assign ctrl.load   = accept && !divisorZero;
  assign ctrl.step   = (state == ST_RUN);
  assign ctrl.finish = (state == ST_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      iterCnt   <= '0;
      modeR     <= 1'b0;
      done      <= 1'b0;
      rangeExc  <= 1'b0;
      quotValid <= 1'b0;
      ovFlag    <= 1'b0;
      cyFlag    <= 1'b0;
    end else begin
      done     <= 1'b0;
      rangeExc <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (divisorZero) begin
              done      <= 1'b1;
              quotValid <= 1'b0;
              rangeExc  <= ovExcEn;
              if (signedMode) ovFlag <= 1'b1;
              else            cyFlag <= 1'b1;
            end else begin
              state   <= ST_RUN;
              iterCnt <= '0;
              modeR   <= signedMode;
            end
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          done      <= 1'b1;
          quotValid <= 1'b1;
          if (modeR) ovFlag <= 1'b0;
          else       cyFlag <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/int_divider.sv
module int_divider
  import divz_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             ovExcEn,
  output logic [WIDTH-1:0] quotient,
  output logic             quotValid,
  output logic             ovFlag,
  output logic             cyFlag,
  output logic             done,
  output logic             rangeExc
);

  dpCtrl_t ctrl;
  logic    divisorZero;
  logic    busy;

  divz_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .signedMode (signedMode),
    .ovExcEn    (ovExcEn),
    .divisorZero(divisorZero),
    .ctrl       (ctrl),
    .busy       (busy),
    .done       (done),
    .rangeExc   (rangeExc),
    .quotValid  (quotValid),
    .ovFlag     (ovFlag),
    .cyFlag     (cyFlag)
  );

  divz_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .signedMode (signedMode),
    .dividend   (dividend),
    .divisor    (divisor),
    .divisorZero(divisorZero),
    .quotient   (quotient)
  );

endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic             signedMode,
  input logic [WIDTH-1:0] divisor,
  input logic             ovExcEn,
  input logic [WIDTH-1:0] quotient,
  input logic             quotValid,
  input logic             ovFlag,
  input logic             cyFlag,
  input logic             done,
  input logic             rangeExc,
  input logic             busy
);

  logic zeroStart;
  assign zeroStart = startIn && !busy && (divisor == '0);

  // R2: signed zero divisor raises overflow, keeps carry and quotient
  a_r2_signed_zero: assert property (@(posedge clk) disable iff (!rstN)
    zeroStart && signedMode |=> ovFlag && done && !quotValid
      && (cyFlag == $past(cyFlag)) && $stable(quotient));

  // R4: unsigned zero divisor raises carry, keeps overflow and quotient
  a_r4_unsigned_zero: assert property (@(posedge clk) disable iff (!rstN)
    zeroStart && !signedMode |=> cyFlag && done && !quotValid
      && (ovFlag == $past(ovFlag)) && $stable(quotient));

  // R5: exception pulse follows the enable sampled at a zero-divisor start
  a_r5_exc_follows_enable: assert property (@(posedge clk) disable iff (!rstN)
    zeroStart |=> rangeExc == $past(ovExcEn));

  // R5: exception only appears with done and without a quotient
  a_r5_exc_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rangeExc |-> done && !quotValid);

  // R8: a start while busy never produces an exception pulse
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy && startIn |=> !rangeExc);

endmodule

bind int_divider int_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startIn   (startIn),
  .signedMode(signedMode),
  .divisor   (divisor),
  .ovExcEn   (ovExcEn),
  .quotient  (quotient),
  .quotValid (quotValid),
  .ovFlag    (ovFlag),
  .cyFlag    (cyFlag),
  .done      (done),
  .rangeExc  (rangeExc),
  .busy      (busy)
);

// File: tb/tb_int_divider.sv
module tb_int_divider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        ovExcEn = 1'b0;
  logic [31:0] quotient;
  logic        quotValid;
  logic        ovFlag;
  logic        cyFlag;
  logic        done;
  logic        rangeExc;

  int checks = 0;
  int errors = 0;

  logic [31:0] expQ = '0;
  logic        expOv = 1'b0;
  logic        expCy = 1'b0;

  always #10 clk = ~clk;

  int_divider dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .ovExcEn(ovExcEn),
    .quotient(quotient), .quotValid(quotValid), .ovFlag(ovFlag),
    .cyFlag(cyFlag), .done(done), .rangeExc(rangeExc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refQuot(input bit sgn, input logic [31:0] a,
                                          input logic [31:0] b);
    longint sa, sb, sq;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      sq = sa / sb;
      return sq[31:0];
    end
    return a / b;
  endfunction

  // drives one division; if skipWait the caller is already at a negedge
  task automatic runOp(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                       input bit en, input bit skipWait);
    int n;
    bit seenExc;
    string tagQ;
    if (!skipWait) @(negedge clk);
    startIn = 1'b1; signedMode = sgn; dividend = a; divisor = b; ovExcEn = en;
    @(negedge clk);
    startIn = 1'b0;
    n = 1;
    seenExc = 1'b0;
    while (!done && n < 60) begin
      if (rangeExc) seenExc = 1'b1;
      @(negedge clk);
      n++;
    end
    if (b == 0) begin
      tagQ = sgn ? "R2" : "R4";
      if (sgn) expOv = 1'b1; else expCy = 1'b1;
      check(n == 1, "R7 zero-divisor latency", n, 1);
      check(quotValid == 1'b0, tagQ, quotValid, 0);
      check(rangeExc == en && !seenExc, "R5 exception on zero divisor", rangeExc, en);
    end else begin
      tagQ = sgn ? "R1" : "R3";
      expQ = refQuot(sgn, a, b);
      if (sgn) expOv = 1'b0; else expCy = 1'b0;
      check(n == 34, "R7 division latency", n, 34);
      check(quotValid == 1'b1, tagQ, quotValid, 1);
      check(rangeExc == 1'b0 && !seenExc, "R5 no exception on nonzero divisor",
            rangeExc, 0);
    end
    check(quotient == expQ, tagQ, quotient, expQ);
    check(ovFlag == expOv, tagQ, ovFlag, expOv);
    check(cyFlag == expCy, tagQ, cyFlag, expCy);
  endtask

  task automatic testReset();
    check(quotient == 0, "R9 quotient", quotient, 0);
    check({quotValid, ovFlag, cyFlag, done, rangeExc} == 5'b0, "R9 status bits",
          {quotValid, ovFlag, cyFlag, done, rangeExc}, 0);
  endtask

  task automatic testSignedBasics();
    runOp(1, 32'd100, 32'd7, 1, 0);
    runOp(1, -32'sd100, 32'd7, 1, 0);
    runOp(1, 32'd100, -32'sd7, 0, 0);
    runOp(1, -32'sd100, -32'sd7, 0, 0);
    runOp(1, -32'sd7, 32'd2, 0, 0);
  endtask

  task automatic testZeroAndFlags();
    runOp(1, 32'd55, 32'd0, 0, 0);          // R2 with exception disabled
    runOp(0, 32'hFFFF_FFFF, 32'd3, 1, 0);   // R3 keeps ov set
    runOp(0, 32'd9, 32'd0, 1, 0);           // R4 with exception enabled
    runOp(1, 32'd40, 32'd5, 1, 0);          // R1 keeps cy set
    runOp(0, 32'd40, 32'd6, 0, 0);          // R3 clears cy
    runOp(1, 32'd1, 32'd0, 1, 0);           // R2 with exception enabled
    runOp(0, 32'd1, 32'd0, 0, 0);           // R4 with exception disabled
  endtask

  task automatic testMinByMinusOne();
    runOp(1, 32'd3, 32'd0, 0, 0);           // make ov set first
    runOp(1, 32'h8000_0000, 32'hFFFF_FFFF, 1, 0);
    check(quotient == 32'h8000_0000, "R6 quotient", quotient, 32'h8000_0000);
    check(ovFlag == 1'b0, "R6 ov cleared", ovFlag, 0);
  endtask

  task automatic testBackToBack();
    runOp(0, 32'd1000, 32'd10, 0, 0);
    // start a zero-divisor op in the very cycle done is high (R7)
    runOp(1, 32'd5, 32'd0, 1, 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", done, 0);
  endtask

  task automatic testBusyIgnored();
    int n;
    bit seenExc;
    logic cyBefore;
    cyBefore = cyFlag;
    @(negedge clk);
    startIn = 1'b1; signedMode = 1'b1; dividend = 32'd999; divisor = 32'd9; ovExcEn = 1'b0;
    @(negedge clk);
    startIn = 1'b0;
    n = 1;
    seenExc = 1'b0;
    repeat (4) begin @(negedge clk); n++; end
    startIn = 1'b1; signedMode = 1'b0; divisor = 32'd0; ovExcEn = 1'b1;
    @(negedge clk); n++;
    startIn = 1'b0;
    while (!done && n < 60) begin
      if (rangeExc) seenExc = 1'b1;
      @(negedge clk);
      n++;
    end
    expQ = 32'd111;
    expOv = 1'b0;
    check(n == 34, "R8 latency unchanged", n, 34);
    check(quotient == 32'd111, "R8 result kept", quotient, 32'd111);
    check(!seenExc && !rangeExc, "R8 no exception", rangeExc, 0);
    check(cyFlag == cyBefore, "R8 carry untouched", cyFlag, cyBefore);
    check(ovFlag == 1'b0, "R8 overflow from running op", ovFlag, 0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      bit sgn;
      a = $urandom();
      b = $urandom();
      sgn = i[0];
      if (i % 7 == 3) b = 0;
      else if (i % 5 == 1) b = b >> (b[4:0]);
      if (b == 0 && i % 7 != 3) b = 32'd1;
      runOp(sgn, a, b, i[1], 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSignedBasics();
    testZeroAndFlags();
    testMinByMinusOne();
    testBackToBack();
    testBusyIgnored();
    testRandom();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule